// File: doc/BRIEF.md
# ATM Cell Framer with Command Octet Insertion

This block sits between a cell source and a line symbol encoder. It takes fixed-length ATM cells one octet per clock over a valid/ready handshake. It sends them out as a tagged octet stream, where each output octet is marked as either scrambled cell data or a command octet. A command octet is formed from an escape nibble (`4'hF`) in the upper half and a code nibble in the lower half. The encoder downstream takes one octet per clock, so every clock is one octet slot.

Each cell is preceded by a start-of-cell command. That command comes in two forms. One form reloads the payload scrambler with its seed. The other form leaves the scrambler running. Cell octets are XORed with a key drawn from a nibble-stepped LFSR. A rising edge on the 8 kHz sync input forces a timing-marker command into the very next slot. This takes priority over anything else, including a cell in progress. The interrupted cell continues afterwards with no lost or repeated octet.

Top module: `atm_cell_framer`

## Requirements
- R1: While `rst_n` is low, and in the first slot after its release, `out_valid` and `in_ready` are both low.
- R2: Each cell of CELL_LEN (53) octets is preceded by exactly one start-of-cell command octet. While that command is issued, `in_ready` is low. After the command, the 53 octets are accepted and emitted one per clock, each one clock after its handshake.
- R3: The start-of-cell command is 8'hFF (resetting form) when `soc_reset_sel` is high in the clock it is issued, and always for the first cell after reset. The resetting form loads the generator with its seed (default 7'h2B), so the cell's first data octet is scrambled from the seed.
- R4: The start-of-cell command is 8'hF4 (plain form) otherwise. The generator state carries on unchanged from the previous cell.
- R5: A data octet equals the input octet XOR an 8-bit key. The key is built from two 4-bit generator steps. Each bit step takes the parity of state AND taps (default 7'h60), shifts it in at the LSB, and places it in the key MSB first. Only data octets advance the generator.
- R6: A clock in which `sync_in` is high after being low produces the marker command 8'hF8 on the next clock, whatever else is pending. In that clock `in_ready` is low, no start-of-cell is issued, and the generator does not advance. The cell then resumes with its next octet.
- R7: `sync_in` held high for several clocks produces a single marker.
- R8: With no cell offered, `out_valid` stays low and no filler is emitted. If the source drops `in_valid` inside a cell, that slot carries no output.
- R9: `out_is_cmd` is high on every command octet and low on every data octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a cell octet |
| in_data | input | 8 | Cell octet from the source |
| in_ready | output | 1 | Octet accepted this clock |
| soc_reset_sel | input | 1 | Request the resetting start-of-cell form for the next cell |
| sync_in | input | 1 | 8 kHz timing pulse, rising edge active |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Scrambled data or command octet |
| out_is_cmd | output | 1 | Tag: 1 for a command octet |

## Verification
A wrong generator state does not show up in a command octet. It shows up as a wrong key on the very next data octet. The case to watch is an advance during a marker or a start-of-cell command, which would corrupt every later octet of the cell. A wrong cell count shows up as a start-of-cell command that comes too early or too late, within one cell length. A lost sync edge shows up as a missing marker one clock after the edge. For these reasons, the reference model compares every output slot and `in_ready` on every clock, across resumed cells, back-to-back cells and source stalls.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam logic [3:0] ESC_NIB      = 4'hF;
    localparam logic [3:0] CODE_SOC_RST = 4'hF;
    localparam logic [3:0] CODE_SOC     = 4'h4;
    localparam logic [3:0] CODE_MARK    = 4'h8;

    localparam logic [7:0] CMD_SOC_RST = {ESC_NIB, CODE_SOC_RST};
    localparam logic [7:0] CMD_SOC     = {ESC_NIB, CODE_SOC};
    localparam logic [7:0] CMD_MARK    = {ESC_NIB, CODE_MARK};

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CELL = 1'b1
    } frm_state_e;

    typedef struct packed {
        logic       valid;
        logic       is_cmd;
        logic [7:0] data;
    } octet_t;

endpackage

// File: rtl/framer_sync_edge.sv
module framer_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = pulse_in;
        rise     = pulse_in & ~r_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/framer_scrambler.sv
module framer_scrambler #(
    parameter int              LFSR_W = 7,
    parameter logic [LFSR_W-1:0] TAPS = 7'h60,
    parameter logic [LFSR_W-1:0] SEED = 7'h2B,
    parameter int              NIB_W  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       advance,
    output logic [7:0] key
);
    localparam int STEPS = 8 / NIB_W;

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } scr_t;

    scr_t s_d, s_q;
    logic [LFSR_W-1:0] walk;
    logic              fb;

    always_comb begin
        walk = s_q.state;
        key  = '0;
        fb   = 1'b0;
        for (int n = 0; n < STEPS; n++) begin
            for (int b = 0; b < NIB_W; b++) begin
                fb   = ^(walk & TAPS);
                key[7 - (n * NIB_W + b)] = fb;
                walk = {walk[LFSR_W-2:0], fb};
            end
        end
        s_d = s_q;
        if (load)         s_d.state = SEED;
        else if (advance) s_d.state = walk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.state <= SEED;
        else        s_q       <= s_d;
    end
endmodule

// File: rtl/atm_cell_framer.sv
module atm_cell_framer #(
    parameter int                CELL_LEN = 53,
    parameter int                LFSR_W   = 7,
    parameter logic [LFSR_W-1:0] TAPS     = 7'h60,
    parameter logic [LFSR_W-1:0] SEED     = 7'h2B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       soc_reset_sel,
    input  logic       sync_in,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_is_cmd
);
    import framer_pkg::*;

    localparam int               CNT_W = $clog2(CELL_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(CELL_LEN - 1);

    typedef struct packed {
        frm_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             first;
        octet_t           o;
    } ctl_t;

    ctl_t c_d, c_q;
    logic       sync_rise;
    logic       scr_load;
    logic       scr_adv;
    logic [7:0] key;

    framer_sync_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (sync_in),
        .rise     (sync_rise)
    );

    framer_scrambler #(
        .LFSR_W (LFSR_W),
        .TAPS   (TAPS),
        .SEED   (SEED),
        .NIB_W  (4)
    ) i_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (scr_load),
        .advance (scr_adv),
        .key     (key)
    );

    always_comb begin
        c_d        = c_q;
        c_d.o.valid = 1'b0;
        in_ready   = 1'b0;
        scr_load   = 1'b0;
        scr_adv    = 1'b0;
        if (sync_rise) begin
            c_d.o.valid  = 1'b1;
            c_d.o.is_cmd = 1'b1;
            c_d.o.data   = CMD_MARK;
        end else if (c_q.st == ST_CELL) begin
            if (in_valid) begin
                in_ready     = 1'b1;
                scr_adv      = 1'b1;
                c_d.o.valid  = 1'b1;
                c_d.o.is_cmd = 1'b0;
                c_d.o.data   = in_data ^ key;
                if (c_q.cnt == LAST) begin
                    c_d.st  = ST_IDLE;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
        end else if (in_valid) begin
            c_d.o.valid  = 1'b1;
            c_d.o.is_cmd = 1'b1;
            if (soc_reset_sel || c_q.first) begin
                scr_load   = 1'b1;
                c_d.o.data = CMD_SOC_RST;
            end else begin
                c_d.o.data = CMD_SOC;
            end
            c_d.first = 1'b0;
            c_d.st    = ST_CELL;
            c_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_IDLE;
            c_q.cnt   <= '0;
            c_q.first <= 1'b1;
            c_q.o     <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_valid  = c_q.o.valid;
    assign out_data   = c_q.o.data;
    assign out_is_cmd = c_q.o.is_cmd;
endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
    parameter int CELL_LEN = 53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       sync_in,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_is_cmd
);
    logic     prev_sync;
    logic     seen_soc;
    int       data_cnt;
    logic     rise;

    assign rise = sync_in && !prev_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sync <= 1'b0;
            seen_soc  <= 1'b0;
            data_cnt  <= 0;
        end else begin
            prev_sync <= sync_in;
            if (out_valid && out_is_cmd && out_data != 8'hF8) begin
                seen_soc <= 1'b1;
                data_cnt <= 0;
            end else if (out_valid && !out_is_cmd) begin
                data_cnt <= data_cnt + 1;
            end
        end
    end

    // R6
    a_r6_marker_next: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (out_valid && out_is_cmd && out_data == 8'hF8));
    // R6
    a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> !in_ready);
    // R2
    a_r2_accept_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !out_is_cmd));
    // R2
    a_r2_cell_len: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_cmd) |-> (seen_soc && data_cnt < CELL_LEN));
    // R2
    a_r2_soc_place: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cmd && out_data != 8'hF8) |-> (!seen_soc || data_cnt == CELL_LEN));
    // R9
    a_r9_cmd_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_cmd) |-> (out_data == 8'hFF || out_data == 8'hF4 || out_data == 8'hF8));
    // R8
    a_r8_no_filler: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !rise) |=> !(out_valid && !out_is_cmd));
endmodule

bind atm_cell_framer framer_checker #(.CELL_LEN(CELL_LEN)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sync_in    (sync_in),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_is_cmd (out_is_cmd)
);

// File: tb/test_atm_cell_framer.sv
module test_atm_cell_framer;
    localparam int         CLK_PERIOD = 10;
    localparam int         CELL       = 53;
    localparam logic [6:0] M_TAPS     = 7'h60;
    localparam logic [6:0] M_SEED     = 7'h2B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       soc_reset_sel = 1'b0;
    logic       sync_in = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_is_cmd;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    byte unsigned src[$];

    // reference model state
    bit         m_cell = 0;
    int         m_cnt = 0;
    bit         m_first = 1;
    bit         m_prev = 0;
    logic [6:0] m_lfsr = M_SEED;
    bit         e_valid = 0;
    bit         e_cmd = 0;
    logic [7:0] e_data = '0;
    string      e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    atm_cell_framer i_atm_cell_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .soc_reset_sel(soc_reset_sel), .sync_in(sync_in),
        .out_valid(out_valid), .out_data(out_data), .out_is_cmd(out_is_cmd)
    );

    function automatic logic [7:0] key_of(input logic [6:0] s);
        logic [7:0] k;
        logic       b;
        k = '0;
        for (int i = 0; i < 8; i++) begin
            b = ^(s & M_TAPS);
            k[7-i] = b;
            s = {s[5:0], b};
        end
        return k;
    endfunction

    function automatic logic [6:0] adv_of(input logic [6:0] s);
        logic b;
        for (int i = 0; i < 8; i++) begin
            b = ^(s & M_TAPS);
            s = {s[5:0], b};
        end
        return s;
    endfunction

    task automatic step(input bit en, input bit sel, input bit sy);
        bit rise, rdy;
        @(negedge clk);
        in_valid      = en && (src.size() > 0);
        in_data       = in_valid ? src[0] : 8'h00;
        soc_reset_sel = sel;
        sync_in       = sy;
        #1;
        // compare outputs registered at the previous edge
        compared++;
        if (out_valid !== e_valid ||
            (e_valid && (out_is_cmd !== e_cmd || out_data !== e_data))) begin
            mismatched++;
            $display("FAIL %s: out v/c/d=%0b/%0b/%02h expected %0b/%0b/%02h at %0t",
                     e_tag, out_valid, out_is_cmd, out_data, e_valid, e_cmd, e_data, $time);
        end
        rise = rst_n && sy && !m_prev;
        rdy  = rst_n && !rise && m_cell && in_valid;
        compared++;
        if (in_ready !== rdy) begin
            mismatched++;
            $display("FAIL %s: in_ready=%0b expected %0b at %0t",
                     rise ? "R6" : (rst_n ? "R2" : "R1"), in_ready, rdy, $time);
        end
        // next expected slot
        e_valid = 0;
        if (!rst_n) begin
            e_tag = "R1"; m_prev = 0;
        end else begin
            m_prev = sy;
            if (rise) begin
                e_valid = 1; e_cmd = 1; e_data = 8'hF8; e_tag = "R6";
            end else if (m_cell) begin
                if (in_valid) begin
                    e_valid = 1; e_cmd = 0; e_data = in_data ^ key_of(m_lfsr);
                    e_tag = "R5";
                    m_lfsr = adv_of(m_lfsr);
                    m_cnt++;
                    if (m_cnt == CELL) begin m_cell = 0; m_cnt = 0; end
                end else e_tag = "R8";
            end else if (in_valid) begin
                e_valid = 1; e_cmd = 1;
                if (sel || m_first) begin
                    e_data = 8'hFF; m_lfsr = M_SEED; e_tag = "R3";
                end else begin
                    e_data = 8'hF4; e_tag = "R4";
                end
                m_first = 0; m_cell = 1; m_cnt = 0;
            end else e_tag = "R8";
            if (in_valid && rdy) void'(src.pop_front());
        end
    endtask

    task automatic push_cells(input int n, input int base);
        for (int i = 0; i < n * CELL; i++) src.push_back(8'((base + i * 37) & 8'hFF));
    endtask

    initial begin
        // R1: reset quiet
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        @(negedge clk); rst_n = 1;
        step(0, 0, 0);
        // R2, R3: first cell uses resetting form even with sel low
        push_cells(1, 3);
        for (int i = 0; i < 60; i++) step(1, 0, 0);
        // R4: plain form continues generator; R9 tags
        push_cells(1, 11);
        for (int i = 0; i < 60; i++) step(1, 0, 0);
        // R6 mid-cell marker, R7 held sync gives one marker, R3 resetting form
        push_cells(1, 29);
        for (int i = 0; i < 70; i++) step(1, 1, (i == 20) || (i >= 40 && i < 46));
        // R8 idle: no filler, sync alone yields only a marker
        for (int i = 0; i < 10; i++) step(1, 0, i == 4);
        // back-to-back cells, stalls, sync on the start-of-cell slot, alternating forms
        push_cells(2, 77);
        for (int i = 0; i < 200; i++) step((i % 3) != 2, (i / 50) % 2 == 1, (i == 0) || (i == 90));
        // R2 back-to-back with no stall
        push_cells(2, 5);
        for (int i = 0; i < 115; i++) step(1, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule